// File: doc/BRIEF.md
# Port-Size Byte Lane Steering

This block places one CPU-side access on the byte lanes of an external data port whose width is chosen per bank: 8, 16 or 32 bits. The bus is big-endian, and its bit 0 is the most significant bit. Lane 0 carries bus bits 0-7, which are vector bits [31:24]. Lane 3 carries bus bits 24-31, which are vector bits [7:0]. A narrow port always sits on the most-significant lanes. An 8-bit port uses lane 0 only, and a 16-bit port uses lanes 0 and 1.

For each request the block reports which lanes are enabled, whether the access is legal for the port, and the first lane used, given as a steering select. It also moves data for a single beat in both directions. Write data arrives right-justified from the CPU and is placed on the enabled bus lanes. Read data is taken from the enabled bus lanes and returned right-justified. All outputs are registered and appear one clock after the request. An access that would need more than one beat on the selected port is flagged as illegal; the block does not split accesses.

Encodings: `acc_size` 00 = byte, 01 = half-word, 10 = word, 11 = reserved. `port_size` 00 = 32-bit, 01 = 8-bit, 10 = 16-bit, 11 = reserved.

Top module: `lane_steer`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero in the following cycle.
- R2: `out_valid` equals `req_valid` delayed by one clock. When `out_valid` is 0, `lane_en`, `out_illegal`, `steer_sel`, `bus_wdata` and `cpu_rdata` are all zero.
- R3: On a 32-bit port (`port_size`=00), a byte access at offset a (0..3) sets only `lane_en` bit a. Lane 0 is bus bits 0-7, which are vector bits [31:24].
- R4: On a 32-bit port, a half-word at offset 0 enables lanes 0 and 1, and a half-word at offset 2 enables lanes 2 and 3. A word at offset 0 enables all four lanes.
- R5: On a 16-bit port (`port_size`=10), a byte at an even address enables lane 0 and a byte at an odd address enables lane 1. A half-word at an even address enables lanes 0 and 1. Lanes 2 and 3 are never enabled.
- R6: On an 8-bit port (`port_size`=01), a byte at any address enables lane 0 only.
- R7: The following accesses are illegal: a word at an offset other than 0, a half-word at an odd offset, a half-word or word on an 8-bit port, a word on a 16-bit port, and any reserved size or port code. For an illegal access, `out_illegal`=1, and `lane_en`, `steer_sel`, `bus_wdata` and `cpu_rdata` are zero.
- R8: For a legal access, `steer_sel` is the index of the lowest-numbered enabled lane.
- R9: For a legal access, CPU write data is placed on the bus so that its least-significant byte (`cpu_wdata[7:0]`) lands on the highest-numbered enabled lane. The more significant bytes follow on the lower-numbered lanes, and disabled lanes read zero.
- R10: For a legal access, the bytes on the enabled bus lanes are returned right-justified on `cpu_rdata`. The highest-numbered enabled lane goes to bits [7:0], and all bits above the access size are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| acc_size | input | 2 | Access size code |
| addr_lo | input | 2 | Low address bits (byte offset) |
| port_size | input | 2 | Port width code of the selected bank |
| cpu_wdata | input | 32 | Right-justified CPU write data |
| bus_rdata | input | 32 | Read data sampled from the external bus |
| out_valid | output | 1 | Registered result valid |
| out_illegal | output | 1 | Access not allowed on this port |
| lane_en | output | 4 | Byte-lane enables, bit n = lane n |
| steer_sel | output | 2 | First lane used by the access |
| bus_wdata | output | 32 | Write data steered onto bus lanes |
| cpu_rdata | output | 32 | Right-justified read data |

## Verification
The cases that are hardest to reach are the ones where the same offset means different things on different ports. For example, offset 3 is lane 3 on a 32-bit port, lane 1 on a 16-bit port and lane 0 on an 8-bit port. The reserved codes that must be turned away are another such case. To reach them, the stimulus sweeps every combination of port code, size code and offset, including the reserved codes. Each combination is applied twice with fresh random data, and idle cycles are placed between groups. Because each byte of the random data is distinct, a byte placed on the wrong lane shows up in the data comparison and not only in the lane enables.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSV  = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    PORT_32  = 2'b00,
    PORT_8   = 2'b01,
    PORT_16  = 2'b10,
    PORT_RSV = 2'b11
  } port_size_e;
endpackage

// File: rtl/lane_steer_decode.sv
module lane_steer_decode
  import lane_steer_pkg::*;
#(
  parameter int LANES = 4,
  localparam int LW = $clog2(LANES),
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic [1:0]       acc_size,
  input  logic [LW-1:0]    addr_lo,
  input  logic [1:0]       port_size,
  output logic             legal,
  output logic [LANES-1:0] lane_en,
  output logic [LW-1:0]    first,
  output logic [CW-1:0]    nbytes
);
  logic [CW-1:0] port_bytes;
  logic [CW-1:0] acc_bytes;
  logic [LW-1:0] off;
  logic          aligned;

  always_comb begin
    case (port_size_e'(port_size))
      PORT_32: port_bytes = CW'(LANES);
      PORT_16: port_bytes = CW'(LANES / 2);
      PORT_8:  port_bytes = CW'(1);
      default: port_bytes = '0;
    endcase
    case (acc_size_e'(acc_size))
      SZ_BYTE: acc_bytes = CW'(1);
      SZ_HALF: acc_bytes = CW'(2);
      SZ_WORD: acc_bytes = CW'(4);
      default: acc_bytes = '0;
    endcase
    // narrow ports fold the offset onto the most-significant lanes
    off     = addr_lo & LW'(port_bytes - CW'(1));
    aligned = (addr_lo & LW'(acc_bytes - CW'(1))) == '0;
    legal   = (acc_bytes != '0) && (port_bytes != '0) &&
              (acc_bytes <= port_bytes) && aligned;
    for (int k = 0; k < LANES; k++) begin
      lane_en[k] = legal && (k >= int'(off)) && (k < int'(off) + int'(acc_bytes));
    end
    first  = legal ? off : '0;
    nbytes = legal ? acc_bytes : '0;
  end
endmodule

// File: rtl/lane_steer_wr.sv
module lane_steer_wr #(
  parameter int LANES = 4,
  parameter int BW = 8,
  localparam int DW = LANES * BW,
  localparam int LW = $clog2(LANES),
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] lane_en,
  input  logic [LW-1:0]    first,
  input  logic [CW-1:0]    nbytes,
  input  logic [DW-1:0]    cpu_wdata,
  output logic [DW-1:0]    bus_wdata
);
  int shift;
  assign shift = LANES - int'(nbytes) - int'(first);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    int src;
    int idx;
    always_comb begin
      src = k + shift;
      idx = (src >= 0 && src < LANES) ? src : 0;
      if (lane_en[k] && src >= 0 && src < LANES)
        bus_wdata[(LANES-1-k)*BW +: BW] = cpu_wdata[(LANES-1-idx)*BW +: BW];
      else
        bus_wdata[(LANES-1-k)*BW +: BW] = '0;
    end
  end
endmodule

// File: rtl/lane_steer_rd.sv
module lane_steer_rd #(
  parameter int LANES = 4,
  parameter int BW = 8,
  localparam int DW = LANES * BW,
  localparam int LW = $clog2(LANES),
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] lane_en,
  input  logic [LW-1:0]    first,
  input  logic [CW-1:0]    nbytes,
  input  logic [DW-1:0]    bus_rdata,
  output logic [DW-1:0]    cpu_rdata
);
  int shift;
  assign shift = LANES - int'(nbytes) - int'(first);

  for (genvar m = 0; m < LANES; m++) begin : g_slot
    int src;
    int idx;
    always_comb begin
      src = m - shift;
      idx = (src >= 0 && src < LANES) ? src : 0;
      if (src >= 0 && src < LANES && lane_en[idx])
        cpu_rdata[(LANES-1-m)*BW +: BW] = bus_rdata[(LANES-1-idx)*BW +: BW];
      else
        cpu_rdata[(LANES-1-m)*BW +: BW] = '0;
    end
  end
endmodule

// File: rtl/lane_steer.sv
module lane_steer #(
  parameter int LANES = 4,
  parameter int BW = 8,
  localparam int DW = LANES * BW,
  localparam int LW = $clog2(LANES),
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       acc_size,
  input  logic [LW-1:0]    addr_lo,
  input  logic [1:0]       port_size,
  input  logic [DW-1:0]    cpu_wdata,
  input  logic [DW-1:0]    bus_rdata,
  output logic             out_valid,
  output logic             out_illegal,
  output logic [LANES-1:0] lane_en,
  output logic [LW-1:0]    steer_sel,
  output logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    cpu_rdata
);
  logic             d_legal;
  logic [LANES-1:0] d_lanes;
  logic [LW-1:0]    d_first;
  logic [CW-1:0]    d_nbytes;
  logic [DW-1:0]    d_wdata;
  logic [DW-1:0]    d_rdata;

  lane_steer_decode #(.LANES(LANES)) u_dec (
    .acc_size (acc_size),
    .addr_lo  (addr_lo),
    .port_size(port_size),
    .legal    (d_legal),
    .lane_en  (d_lanes),
    .first    (d_first),
    .nbytes   (d_nbytes)
  );

  lane_steer_wr #(.LANES(LANES), .BW(BW)) u_wr (
    .lane_en  (d_lanes),
    .first    (d_first),
    .nbytes   (d_nbytes),
    .cpu_wdata(cpu_wdata),
    .bus_wdata(d_wdata)
  );

  lane_steer_rd #(.LANES(LANES), .BW(BW)) u_rd (
    .lane_en  (d_lanes),
    .first    (d_first),
    .nbytes   (d_nbytes),
    .bus_rdata(bus_rdata),
    .cpu_rdata(d_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      out_valid   <= rst ? 1'b0 : req_valid;
      out_illegal <= 1'b0;
      lane_en     <= '0;
      steer_sel   <= '0;
      bus_wdata   <= '0;
      cpu_rdata   <= '0;
    end else begin
      out_valid   <= 1'b1;
      out_illegal <= !d_legal;
      lane_en     <= d_lanes;
      steer_sel   <= d_first;
      bus_wdata   <= d_wdata;
      cpu_rdata   <= d_rdata;
    end
  end
endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk #(
  parameter int LANES = 4,
  parameter int BW = 8,
  localparam int DW = LANES * BW,
  localparam int LW = $clog2(LANES)
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [1:0]       acc_size,
  input logic [1:0]       port_size,
  input logic             out_valid,
  input logic             out_illegal,
  input logic [LANES-1:0] lane_en,
  input logic [LW-1:0]    steer_sel,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    cpu_rdata
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (lane_en == '0 && !out_illegal && bus_wdata == '0 && cpu_rdata == '0));
  assert_illegal_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (lane_en == '0 && steer_sel == '0 && bus_wdata == '0 && cpu_rdata == '0));
  assert_legal_lanes_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_illegal) |->
      ($countones(lane_en) == 1 || $countones(lane_en) == 2 || $countones(lane_en) == 4));
  assert_port8_lane0_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && port_size == 2'b01) |=> (lane_en[LANES-1:1] == '0));
  assert_port16_upper_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && port_size == 2'b10) |=> (lane_en[LANES-1:2] == '0));
  assert_rsv_illegal_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (port_size == 2'b11 || acc_size == 2'b11)) |=> out_illegal);
  assert_steer_first_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_illegal) |->
      (lane_en[steer_sel] && (steer_sel == '0 || !lane_en[steer_sel - 1'b1])));

  for (genvar k = 0; k < LANES; k++) begin : g_wlane
    assert_wdata_off_lane_R9: assert property (@(posedge clk) disable iff (rst)
      !lane_en[k] |-> (bus_wdata[(LANES-1-k)*BW +: BW] == '0));
  end
endmodule

bind lane_steer lane_steer_chk #(.LANES(LANES), .BW(BW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .acc_size   (acc_size),
  .port_size  (port_size),
  .out_valid  (out_valid),
  .out_illegal(out_illegal),
  .lane_en    (lane_en),
  .steer_sel  (steer_sel),
  .bus_wdata  (bus_wdata),
  .cpu_rdata  (cpu_rdata)
);

// File: tb/lane_steer_test.sv
module lane_steer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  acc_size = '0;
  logic [1:0]  addr_lo = '0;
  logic [1:0]  port_size = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] bus_rdata = '0;
  logic        out_valid;
  logic        out_illegal;
  logic [3:0]  lane_en;
  logic [1:0]  steer_sel;
  logic [31:0] bus_wdata;
  logic [31:0] cpu_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // expected values, captured at each rising edge from the inputs
  logic        e_valid = 0, e_illegal = 0;
  logic [3:0]  e_lanes = '0;
  logic [1:0]  e_sel = '0;
  logic [31:0] e_wdata = '0, e_rdata = '0;
  string       e_tag = "R1";

  lane_steer uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .acc_size(acc_size),
    .addr_lo(addr_lo), .port_size(port_size), .cpu_wdata(cpu_wdata),
    .bus_rdata(bus_rdata), .out_valid(out_valid), .out_illegal(out_illegal),
    .lane_en(lane_en), .steer_sel(steer_sel), .bus_wdata(bus_wdata),
    .cpu_rdata(cpu_rdata)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    int width, n, base;
    logic ok;
    e_valid   = !rst && req_valid;
    e_illegal = 0; e_lanes = '0; e_sel = '0; e_wdata = '0; e_rdata = '0;
    e_tag     = rst ? "R1" : "R2";
    if (e_valid) begin
      width = (port_size == 2'b00) ? 4 : (port_size == 2'b10) ? 2 : (port_size == 2'b01) ? 1 : 0;
      n     = (acc_size == 2'b00) ? 1 : (acc_size == 2'b01) ? 2 : (acc_size == 2'b10) ? 4 : 0;
      ok    = (width != 0) && (n != 0) && (n <= width) && ((int'(addr_lo) % n) == 0);
      if (!ok) begin
        e_illegal = 1;
        e_tag     = "R7";
      end else begin
        base  = int'(addr_lo) % width;
        e_sel = 2'(base);
        e_tag = (width == 1) ? "R6" : (width == 2) ? "R5" : (n == 1) ? "R3" : "R4";
        for (int i = 0; i < n; i++) begin
          int lane, b;
          lane = base + i;
          b    = n - 1 - i;
          e_lanes[lane] = 1'b1;
          e_wdata[31 - 8*lane -: 8] = cpu_wdata[8*b +: 8];
          e_rdata[8*b +: 8] = bus_rdata[31 - 8*lane -: 8];
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(e_tag == "R1" ? "R1" : "R2", "out_valid", 32'(out_valid), 32'(e_valid));
    chk(e_tag, "lane_en", 32'(lane_en), 32'(e_lanes));
    chk(e_illegal ? "R7" : e_tag, "out_illegal", 32'(out_illegal), 32'(e_illegal));
    chk(e_tag == "R7" ? "R7" : "R8", "steer_sel", 32'(steer_sel), 32'(e_sel));
    chk(e_tag == "R7" ? "R7" : "R9", "bus_wdata", bus_wdata, e_wdata);
    chk(e_tag == "R7" ? "R7" : "R10", "cpu_rdata", cpu_rdata, e_rdata);
  endtask

  task automatic apply(input logic v, input logic [1:0] ps, input logic [1:0] sz, input logic [1:0] a);
    @(negedge clk);
    compare_all();
    req_valid = v; port_size = ps; acc_size = sz; addr_lo = a;
    cpu_wdata = {8'hA0 | 8'($urandom % 16), 8'hB0 | 8'($urandom % 16),
                 8'hC0 | 8'($urandom % 16), 8'hD0 | 8'($urandom % 16)};
    bus_rdata = {8'h10 | 8'($urandom % 16), 8'h20 | 8'($urandom % 16),
                 8'h30 | 8'($urandom % 16), 8'h40 | 8'($urandom % 16)};
  endtask

  initial begin
    // R1: hold reset with a request pending; outputs must stay zero
    req_valid = 1; acc_size = 2'b10; port_size = 2'b00; addr_lo = 2'b00;
    cpu_wdata = 32'hDEADBEEF; bus_rdata = 32'h12345678;
    repeat (3) @(negedge clk);
    compare_all();
    @(negedge clk);
    rst = 0; req_valid = 0;
    for (int rep = 0; rep < 2; rep++) begin
      for (int ps = 0; ps < 4; ps++) begin
        for (int sz = 0; sz < 4; sz++) begin
          for (int a = 0; a < 4; a++) begin
            apply(1'b1, 2'(ps), 2'(sz), 2'(a));
          end
          apply(1'b0, 2'(ps), 2'(sz), 2'b00);
        end
      end
    end
    // R1: reset in mid-stream
    apply(1'b1, 2'b00, 2'b10, 2'b00);
    @(negedge clk);
    compare_all();
    rst = 1;
    @(negedge clk);
    compare_all();
    rst = 0; req_valid = 0;
    apply(1'b0, 2'b00, 2'b00, 2'b00);
    apply(1'b0, 2'b00, 2'b00, 2'b00);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule